// File: doc/BRIEF.md
# Parallel Port Enhanced-Mode Cycle Sequencer

This block is the host-side controller for enhanced parallel port data and address cycles. A host reaches it through a small slave interface: a register select, active-low read and write strobes, an 8-bit write bus, a read bus and a ready output. The ready output is pulled low to stretch the host access while a peripheral handshake is in progress. Toward the peripheral, the block drives an 8-bit data bus with an output enable. It also drives an active-low direction line, an active-low data strobe and an active-low address strobe, and it samples an active-low wait line from the peripheral.

When no enhanced cycle is in progress, the pins carry the levels held in a legacy control register, and that register's direction bit sets the bus direction. The direction line, data strobe and address strobe share their pins with the legacy strobe, auto-feed and select-in outputs. Accessing select 3 or 4 starts an enhanced cycle. The sequencer then obeys the wait-line ordering rules, runs the strobe handshake and hands read data back before it releases the host. A cycle-count watchdog aborts any cycle the peripheral never completes and records this in a sticky status flag. The host clears that flag by writing a 1 to it.

Top module: `epp_cycle_seq`

## Requirements
- R1: After synchronous reset, host_rdy=1, p_write_n=1, p_dstb_n=1, p_astb_n=1, p_init_n=1, pd_oe=1, pd_out=0x00, the control register (select 2) reads 0x04 and the status register (select 1) reads 0x00.
- R2: Outside an enhanced cycle, the pins follow the control register: p_write_n = NOT bit0, p_dstb_n = NOT bit1, p_init_n = bit2, p_astb_n = NOT bit3, pd_oe = NOT bit5. Writing select 0 loads the byte driven on pd_out.
- R3: host_rdy goes low in the same clock cycle that a host strobe arrives with select 3 (address) or 4 (data). It stays low until the cycle completes or is aborted.
- R4: If p_wait_n is high when a cycle starts, p_write_n, p_dstb_n and p_astb_n keep their idle levels until p_wait_n has been sampled low.
- R5: A write cycle with bit5=0 drives the host byte on pd_out with pd_oe=1 and p_write_n=0. These are held for one clock before the strobe falls: p_dstb_n for select 4, p_astb_n for select 3. The strobe stays low until p_wait_n is sampled high. It then rises, and host_rdy rises in the same cycle.
- R6: A read cycle (bit0=0) runs with pd_oe=0 and p_write_n=1. The pd_in byte sampled on the edge that raises the strobe is presented on host_rdata (select 3 or 4) once host_rdy is high.
- R7: If a cycle has not completed TMO_CYCLES clocks after its start edge (500 at the default 50 MHz and 10 us), it is aborted. The strobes return to idle, host_rdy rises, status bit0 becomes 1, and an aborted read returns 0xFF.
- R8: Writing select 1 with bit0=1 clears the timeout flag. Writing it with bit0=0 leaves the flag unchanged.
- R9: With control bit0=1, an enhanced cycle of either direction drives pd_oe=1 and p_write_n=0.
- R10: With control bit5=1, a host write to select 3 or 4 runs as a read on the pins (pd_oe=0, p_write_n=1). The pd_out latch is not changed and no timeout flag is set.
- R11: One host strobe assertion runs at most one cycle: while the host keeps its strobe low after completion, no strobe falls again and host_rdy stays high. Writes to selects 5 to 7 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Register select (0 data, 1 status, 2 control, 3 enhanced address, 4 enhanced data) |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| host_rdy | output | 1 | Host ready; low stretches the access |
| pd_out | output | 8 | Peripheral data bus output value |
| pd_oe | output | 1 | Peripheral data bus output enable |
| pd_in | input | 8 | Peripheral data bus input value |
| p_write_n | output | 1 | Direction line / legacy strobe pin, active low |
| p_dstb_n | output | 1 | Data strobe / legacy auto-feed pin, active low |
| p_astb_n | output | 1 | Address strobe / legacy select-in pin, active low |
| p_init_n | output | 1 | Legacy initialise pin |
| p_wait_n | input | 1 | Peripheral wait line, active low |

## Verification
The bench starts cycles both with the wait line already high and with it low. A design that skipped the low-first rule would pulse a strobe during the wait phase, which the bench observes at the pins. It runs the override cases: the legacy strobe bit forcing write mode, and the direction bit turning a host write into a pin-level read. A design that ignored the direction bit would drive the bus and corrupt the output latch. It counts the exact number of stretched clocks before a watchdog abort, in both the waiting-for-low and the strobe phases, so an off-by-one limit shows up as a wrong count. It also checks that the sticky flag only clears on a written 1, and that a host strobe held low after completion does not start a second handshake.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] RS_PDATA   = 3'd0;
    localparam logic [SEL_W-1:0] RS_STATUS  = 3'd1;
    localparam logic [SEL_W-1:0] RS_CTRL    = 3'd2;
    localparam logic [SEL_W-1:0] RS_EPPADDR = 3'd3;
    localparam logic [SEL_W-1:0] RS_EPPDATA = 3'd4;

    localparam logic [DATA_W-1:0] CTRL_RST_VAL  = 8'h04;
    localparam logic [DATA_W-1:0] ABORT_RD_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAITLO,
        SQ_SETUP,
        SQ_STROBE,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic is_write;
        logic is_addr;
    } cyc_kind_t;

    typedef struct packed {
        logic strobe;
        logic autofd;
        logic init;
        logic selin;
        logic dir_in;
    } ctrl_fields_t;

    typedef struct packed {
        logic write_n;
        logic dstb_n;
        logic astb_n;
        logic init_n;
        logic oe;
    } pin_bundle_t;

    function automatic logic sel_is_epp(input logic [SEL_W-1:0] s);
        return (s == RS_EPPADDR) || (s == RS_EPPDATA);
    endfunction

    function automatic ctrl_fields_t decode_ctrl(input logic [DATA_W-1:0] c);
        ctrl_fields_t f;
        f.strobe = c[0];
        f.autofd = c[1];
        f.init   = c[2];
        f.selin  = c[3];
        f.dir_in = c[5];
        return f;
    endfunction

    function automatic int unsigned tmo_cycles(input int unsigned clk_hz,
                                               input int unsigned limit_ns);
        return ((clk_hz / 1_000_000) * limit_ns) / 1000;
    endfunction

endpackage

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic hit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign hit = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && !hit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/epp_seq_fsm.sv
module epp_seq_fsm
    import epp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    input  logic             p_wait_n,
    input  logic             wd_hit,
    output seq_state_e       state,
    output cyc_kind_t        cyc,
    output logic             start,
    output logic             reg_wr_go,
    output logic             complete,
    output logic             abort,
    output logic             busy,
    output logic             host_rdy
);
    seq_state_e nxt;
    logic       req;
    logic       epp_req;

    assign req     = !host_rd_n || !host_wr_n;
    assign epp_req = req && sel_is_epp(host_sel);
    assign busy    = (state == SQ_WAITLO) || (state == SQ_SETUP) || (state == SQ_STROBE);
    assign host_rdy = !((state == SQ_IDLE && epp_req) || busy);

    always_comb begin
        nxt       = state;
        start     = 1'b0;
        reg_wr_go = 1'b0;
        complete  = 1'b0;
        abort     = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (epp_req) begin
                    start = 1'b1;
                    nxt   = p_wait_n ? SQ_WAITLO : SQ_SETUP;
                end else if (req) begin
                    reg_wr_go = !host_wr_n;
                    nxt       = SQ_DONE;
                end
            end
            SQ_WAITLO: begin
                if (wd_hit) begin
                    abort = 1'b1;
                    nxt   = SQ_DONE;
                end else if (!p_wait_n) begin
                    nxt = SQ_SETUP;
                end
            end
            SQ_SETUP: begin
                if (wd_hit) begin
                    abort = 1'b1;
                    nxt   = SQ_DONE;
                end else begin
                    nxt = SQ_STROBE;
                end
            end
            SQ_STROBE: begin
                if (p_wait_n) begin
                    complete = 1'b1;
                    nxt      = SQ_DONE;
                end else if (wd_hit) begin
                    abort = 1'b1;
                    nxt   = SQ_DONE;
                end
            end
            SQ_DONE: begin
                if (!req) nxt = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cyc   <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                cyc.is_write <= !host_wr_n;
                cyc.is_addr  <= (host_sel == RS_EPPADDR);
            end
        end
    end
endmodule

// File: rtl/epp_host_regs.sv
module epp_host_regs
    import epp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr_n,
    input  logic              reg_wr_go,
    input  logic              start,
    input  logic              complete,
    input  logic              abort,
    input  cyc_kind_t         cyc,
    input  logic [DATA_W-1:0] pd_in,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] pd_latch,
    output logic              tmo_flag,
    output logic [DATA_W-1:0] host_rdata
);
    logic [DATA_W-1:0] rd_latch;
    ctrl_fields_t      cf;

    assign cf = decode_ctrl(ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_RST_VAL;
            pd_latch <= '0;
            tmo_flag <= 1'b0;
            rd_latch <= '0;
        end else begin
            if (reg_wr_go) begin
                unique case (host_sel)
                    RS_PDATA:  pd_latch <= host_wdata;
                    RS_STATUS: if (host_wdata[0]) tmo_flag <= 1'b0;
                    RS_CTRL:   ctrl <= host_wdata;
                    default:   ;
                endcase
            end
            if (start && !host_wr_n && !cf.dir_in) begin
                pd_latch <= host_wdata;
            end
            if (complete && !cyc.is_write) begin
                rd_latch <= pd_in;
            end
            if (abort) begin
                tmo_flag <= 1'b1;
                if (!cyc.is_write) rd_latch <= ABORT_RD_BYTE;
            end
        end
    end

    always_comb begin
        unique case (host_sel)
            RS_PDATA:               host_rdata = pd_latch;
            RS_STATUS:              host_rdata = {{(DATA_W-1){1'b0}}, tmo_flag};
            RS_CTRL:                host_rdata = ctrl;
            RS_EPPADDR, RS_EPPDATA: host_rdata = rd_latch;
            default:                host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/epp_pin_mux.sv
module epp_pin_mux
    import epp_pkg::*;
(
    input  seq_state_e        state,
    input  cyc_kind_t         cyc,
    input  logic [DATA_W-1:0] ctrl,
    output pin_bundle_t       pins
);
    ctrl_fields_t cf;
    logic         owned;
    logic         eff_write;
    logic         strobing;

    assign cf        = decode_ctrl(ctrl);
    assign owned     = (state == SQ_SETUP) || (state == SQ_STROBE);
    assign eff_write = cyc.is_write && !cf.dir_in;
    assign strobing  = (state == SQ_STROBE);

    always_comb begin
        pins.init_n = cf.init;
        if (owned) begin
            pins.write_n = !(eff_write || cf.strobe);
            pins.oe      = eff_write || cf.strobe;
            pins.dstb_n  = !(strobing && !cyc.is_addr);
            pins.astb_n  = !(strobing && cyc.is_addr);
        end else begin
            pins.write_n = !cf.strobe;
            pins.oe      = !cf.dir_in;
            pins.dstb_n  = !cf.autofd;
            pins.astb_n  = !cf.selin;
        end
    end
endmodule

// File: rtl/epp_cycle_seq.sv
module epp_cycle_seq
    import epp_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned LIMIT_NS = 10_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdy,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [DATA_W-1:0] pd_in,
    output logic              p_write_n,
    output logic              p_dstb_n,
    output logic              p_astb_n,
    output logic              p_init_n,
    input  logic              p_wait_n
);
    localparam int unsigned TMO_CYCLES = tmo_cycles(CLK_HZ, LIMIT_NS);

    seq_state_e        state;
    cyc_kind_t         cyc;
    logic              start, reg_wr_go, complete, abort, busy, wd_hit;
    logic [DATA_W-1:0] ctrl;
    logic              tmo_flag;
    pin_bundle_t       pins;

    epp_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .host_sel  (host_sel),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .p_wait_n  (p_wait_n),
        .wd_hit    (wd_hit),
        .state     (state),
        .cyc       (cyc),
        .start     (start),
        .reg_wr_go (reg_wr_go),
        .complete  (complete),
        .abort     (abort),
        .busy      (busy),
        .host_rdy  (host_rdy)
    );

    epp_watchdog #(.LIMIT(TMO_CYCLES)) u_wd (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .run   (busy),
        .hit   (wd_hit)
    );

    epp_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_wr_n  (host_wr_n),
        .reg_wr_go  (reg_wr_go),
        .start      (start),
        .complete   (complete),
        .abort      (abort),
        .cyc        (cyc),
        .pd_in      (pd_in),
        .ctrl       (ctrl),
        .pd_latch   (pd_out),
        .tmo_flag   (tmo_flag),
        .host_rdata (host_rdata)
    );

    epp_pin_mux u_pins (
        .state (state),
        .cyc   (cyc),
        .ctrl  (ctrl),
        .pins  (pins)
    );

    assign p_write_n = pins.write_n;
    assign p_dstb_n  = pins.dstb_n;
    assign p_astb_n  = pins.astb_n;
    assign p_init_n  = pins.init_n;
    assign pd_oe     = pins.oe;
endmodule

// File: rtl/epp_seq_checker.sv
module epp_seq_checker
    import epp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input seq_state_e        state,
    input cyc_kind_t         cyc,
    input logic [DATA_W-1:0] ctrl,
    input logic              busy,
    input logic              wd_hit,
    input logic              abort,
    input logic              tmo_flag,
    input logic              host_rdy,
    input logic              p_write_n,
    input logic              p_dstb_n,
    input logic              p_astb_n,
    input logic              pd_oe,
    input logic              p_wait_n
);
    AST_RDY_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !host_rdy); // R3

    AST_WAIT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAITLO) |-> ($stable(p_write_n) && $stable(p_dstb_n) && $stable(p_astb_n))); // R4

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STROBE && $past(state) == SQ_SETUP) |-> ($stable(p_write_n) && $stable(pd_oe))); // R5

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STROBE && !p_wait_n && !wd_hit) |=> (state == SQ_STROBE && !(p_dstb_n && p_astb_n))); // R5

    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (rst)
        abort |=> (tmo_flag && host_rdy && state == SQ_DONE)); // R7

    AST_OVERRIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STROBE && ctrl[0]) |-> (!p_write_n && pd_oe)); // R9

    AST_DIR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STROBE && cyc.is_write && ctrl[5] && !ctrl[0]) |-> (p_write_n && !pd_oe)); // R10
endmodule

bind epp_cycle_seq epp_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .cyc       (cyc),
    .ctrl      (ctrl),
    .busy      (busy),
    .wd_hit    (wd_hit),
    .abort     (abort),
    .tmo_flag  (tmo_flag),
    .host_rdy  (host_rdy),
    .p_write_n (p_write_n),
    .p_dstb_n  (p_dstb_n),
    .p_astb_n  (p_astb_n),
    .pd_oe     (pd_oe),
    .p_wait_n  (p_wait_n)
);

// File: tb/tb_epp_cycle_seq.sv
module tb_epp_cycle_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TMO_CYC    = 500;

    typedef struct packed {
        logic [2:0] sel;
        logic       wr;
        logic [7:0] ctrl;
        logic       wait_hi;
        logic [3:0] lat;
        logic [7:0] wdata;
        logic [7:0] pbyte;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'd4, 1'b1, 8'h04, 1'b0, 4'd2, 8'hA5, 8'h00},
        '{3'd3, 1'b1, 8'h04, 1'b1, 4'd0, 8'h3C, 8'h00},
        '{3'd4, 1'b0, 8'h04, 1'b0, 4'd1, 8'h00, 8'hC3},
        '{3'd3, 1'b0, 8'h04, 1'b1, 4'd3, 8'h00, 8'h7E},
        '{3'd4, 1'b1, 8'h24, 1'b0, 4'd1, 8'h5A, 8'h11},
        '{3'd4, 1'b0, 8'h05, 1'b0, 4'd2, 8'h00, 8'h96},
        '{3'd3, 1'b1, 8'h05, 1'b1, 4'd0, 8'h81, 8'h00},
        '{3'd4, 1'b0, 8'h24, 1'b0, 4'd4, 8'h00, 8'h0F}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_sel = 3'd0;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_rdy;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic [7:0] pd_in = 8'h00;
    logic       p_write_n, p_dstb_n, p_astb_n, p_init_n;
    logic       p_wait_n = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] model_latch = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_cycle_seq dut (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .p_write_n(p_write_n), .p_dstb_n(p_dstb_n), .p_astb_n(p_astb_n),
        .p_init_n(p_init_n), .p_wait_n(p_wait_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        host_sel = s;
        #1 d = host_rdata;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic eff_wr, ovr, seen, fin, prev_wn;
        int   lat_cnt;
        string rq;
        eff_wr = v.wr && !v.ctrl[5];
        ovr    = v.ctrl[0];
        rq     = ovr ? "R9" : (v.wr && v.ctrl[5]) ? "R10" : v.wr ? "R5" : "R6";
        reg_write(3'd2, v.ctrl);
        @(negedge clk);
        p_wait_n = v.wait_hi; pd_in = v.pbyte;
        host_sel = v.sel; host_wdata = v.wdata;
        if (v.wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        #1 check(host_rdy == 1'b0, "R3", $sformatf("vec%0d rdy at strobe", idx), host_rdy, 0);
        if (v.wait_hi) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(p_write_n == !v.ctrl[0] && p_dstb_n && p_astb_n, "R4",
                      $sformatf("vec%0d pins before wait low", idx),
                      {p_write_n, p_dstb_n, p_astb_n}, {!v.ctrl[0], 2'b11});
                check(host_rdy == 1'b0, "R3", $sformatf("vec%0d rdy held", idx), host_rdy, 0);
            end
            p_wait_n = 1'b0;
        end
        seen = 1'b0; fin = 1'b0; lat_cnt = 0; prev_wn = p_write_n;
        for (int i = 0; i < 60 && !fin; i++) begin
            @(negedge clk);
            if (!seen && (!p_dstb_n || !p_astb_n)) begin
                seen = 1'b1;
                if (v.sel == 3'd4)
                    check(!p_dstb_n && p_astb_n, "R5", $sformatf("vec%0d data strobe", idx),
                          {p_dstb_n, p_astb_n}, 2'b01);
                else
                    check(!p_astb_n && p_dstb_n, "R5", $sformatf("vec%0d addr strobe", idx),
                          {p_dstb_n, p_astb_n}, 2'b10);
                check(p_write_n == !(eff_wr || ovr), rq, $sformatf("vec%0d nwrite", idx),
                      p_write_n, !(eff_wr || ovr));
                check(pd_oe == (eff_wr || ovr), rq, $sformatf("vec%0d bus enable", idx),
                      pd_oe, eff_wr || ovr);
                check(prev_wn == p_write_n, "R5", $sformatf("vec%0d nwrite setup", idx),
                      prev_wn, p_write_n);
                if (eff_wr) model_latch = v.wdata;
                check(pd_out == model_latch, rq, $sformatf("vec%0d bus value", idx),
                      pd_out, model_latch);
            end
            if (seen) begin
                check(host_rdy == 1'b0, "R3", $sformatf("vec%0d rdy during strobe", idx), host_rdy, 0);
                if (lat_cnt == int'(v.lat)) begin
                    p_wait_n = 1'b1;
                    fin = 1'b1;
                end
                lat_cnt++;
            end
            prev_wn = p_write_n;
        end
        check(seen, "R5", $sformatf("vec%0d strobe seen", idx), seen, 1);
        @(negedge clk);
        check(p_dstb_n && p_astb_n && host_rdy, "R5", $sformatf("vec%0d termination", idx),
              {p_dstb_n, p_astb_n, host_rdy}, 3'b111);
        if (!v.wr)
            check(host_rdata == v.pbyte, "R6", $sformatf("vec%0d read byte", idx),
                  host_rdata, v.pbyte);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(p_dstb_n && p_astb_n && host_rdy, "R11", $sformatf("vec%0d no second cycle", idx),
                  {p_dstb_n, p_astb_n, host_rdy}, 3'b111);
        end
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        @(negedge clk);
        p_wait_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_timeout(input logic [2:0] s, input logic wr, input logic wh,
                               input string tag);
        int cnt;
        bit strobed;
        cnt = 0; strobed = 1'b0;
        @(negedge clk);
        p_wait_n = wh; host_sel = s; host_wdata = 8'h77;
        if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        #1;
        while (!host_rdy && cnt < 2000) begin
            cnt++;
            if (!p_dstb_n || !p_astb_n) strobed = 1'b1;
            @(negedge clk);
            #1;
        end
        check(cnt == TMO_CYC + 1, "R7", {tag, " stretched clocks"}, cnt, TMO_CYC + 1);
        check(p_dstb_n && p_astb_n, "R7", {tag, " strobes idle after abort"},
              {p_dstb_n, p_astb_n}, 2'b11);
        if (wh) check(!strobed, "R4", {tag, " no strobe without wait low"}, strobed, 0);
        if (!wr) check(host_rdata == 8'hFF, "R7", {tag, " abort read byte"}, host_rdata, 8'hFF);
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        @(negedge clk);
        p_wait_n = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(host_rdy && p_write_n && p_dstb_n && p_astb_n && p_init_n && pd_oe, "R1",
              "reset pins", {host_rdy, p_write_n, p_dstb_n, p_astb_n, p_init_n, pd_oe}, 6'h3F);
        check(pd_out == 8'h00, "R1", "reset bus value", pd_out, 0);
        reg_read(3'd2, rd); check(rd == 8'h04, "R1", "reset control", rd, 8'h04);
        reg_read(3'd1, rd); check(rd == 8'h00, "R1", "reset status", rd, 0);

        // R2 idle levels follow control register
        reg_write(3'd2, 8'h2B);
        check({p_write_n, p_dstb_n, p_astb_n, p_init_n, pd_oe} == 5'b00000, "R2",
              "idle pins ctrl 2B", {p_write_n, p_dstb_n, p_astb_n, p_init_n, pd_oe}, 0);
        reg_write(3'd2, 8'h04);
        check({p_write_n, p_dstb_n, p_astb_n, p_init_n, pd_oe} == 5'b11111, "R2",
              "idle pins ctrl 04", {p_write_n, p_dstb_n, p_astb_n, p_init_n, pd_oe}, 5'h1F);
        reg_write(3'd0, 8'h66);
        model_latch = 8'h66;
        check(pd_out == 8'h66, "R2", "data register drives bus", pd_out, 8'h66);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i);
            if (VECS[i].wr && VECS[i].ctrl[5]) begin
                reg_read(3'd0, rd);
                check(rd == model_latch, "R10", "latch kept after blocked write", rd, model_latch);
                reg_read(3'd1, rd);
                check(rd == 8'h00, "R10", "no flag after blocked write", rd, 0);
            end
        end

        // R7 timeout in strobe phase, then R8 clearing
        reg_write(3'd2, 8'h04);
        run_timeout(3'd4, 1'b0, 1'b0, "strobe phase");
        reg_read(3'd1, rd); check(rd[0] == 1'b1, "R7", "flag set", rd, 1);
        reg_write(3'd1, 8'hFE);
        reg_read(3'd1, rd); check(rd[0] == 1'b1, "R8", "write 0 keeps flag", rd, 1);
        reg_write(3'd1, 8'h01);
        reg_read(3'd1, rd); check(rd == 8'h00, "R8", "write 1 clears flag", rd, 0);

        // R7 timeout while waiting for wait line low (R4)
        run_timeout(3'd3, 1'b1, 1'b1, "wait phase");
        reg_read(3'd1, rd); check(rd[0] == 1'b1, "R7", "flag set wait phase", rd, 1);
        reg_write(3'd1, 8'h01);

        // R11 unused selects
        reg_read(3'd0, rd); model_latch = rd;
        reg_write(3'd6, 8'hFF);
        reg_read(3'd2, rd); check(rd == 8'h04, "R11", "control after unused write", rd, 8'h04);
        reg_read(3'd1, rd); check(rd == 8'h00, "R11", "status after unused write", rd, 0);
        check(pd_out == model_latch, "R11", "bus after unused write", pd_out, model_latch);
        reg_read(3'd6, rd); check(rd == 8'h00, "R11", "unused select reads zero", rd, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule